// File: doc/BRIEF.md
# Graphics Command Packet Framer

This block sits at the input of a graphics engine. It takes a stream of 32-bit command words and cuts it into complete packets. The opcode is the top byte of a packet's first word. From the opcode the framer works out how many words make up the packet. For most drawing commands that count is fixed. For polylines the packet instead runs until a terminator word arrives.

Several opcode groups get their own class tag so that a downstream unit can route them: VRAM-to-VRAM copies, image writes into VRAM and image reads out of VRAM. Environment-setting commands never leave the block. They are stored in eight shadow registers, which drive a port of their own. Opcodes that carry no work are dropped.

Words arrive on a valid/ready handshake. A finished packet is held on the output until the consumer takes it, and no input is accepted during that time. Word i of a packet appears at bits [32*i+31 : 32*i] of the word bus. The capacity parameter must be at least 12, because the longest fixed-length packet has 12 words.

Top module: `cmd_packet_framer`

## Requirements
- R1: After reset, inReady is 1, outValid is 0, and shadow register i (bits [32*i+31:32*i] of shadowRegs) holds (0xE0+i) shifted left by 24.
- R2: The following opcodes form fixed packets of class 0 (draw). 0x02 has 3 words in total. For 0x20-0x3F the total is 1 plus an extra-word count chosen by opcode bits 4:2. In the order 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34, 0x38, 0x3C, those counts are 3, 6, 4, 8, 5, 8, 7 and 11. Opcodes 0x40-0x47 take 3 words in total, and 0x50-0x57 take 4.
- R3: Opcodes 0x60-0x7F form class 0 packets whose total is 1 plus an extra-word count chosen by bits 4:2. In the order 0x60, 0x64, 0x68, 0x6C, 0x70, 0x74, 0x78, 0x7C, those counts are 2, 3, 1, 0, 1, 2, 1 and 2. An entry with a count of 0 is dropped, as in R10.
- R4: Opcodes 0x48-0x4F start a class 1 (polyline) packet. The packet ends with, and includes, the first word at index 3 or later whose value ANDed with 0xF000F000 equals 0x50005000.
- R5: Opcodes 0x58-0x5F start a class 1 packet in which the terminator test of R4 is applied only to words at even indices of 4 or more.
- R6: A polyline that reaches MAX_WORDS words without a terminator ends at that word, with a count of MAX_WORDS. The next word then starts a new packet.
- R7: Opcodes 0x80-0x9F form 4-word packets of class 2 (copy).
- R8: Opcodes 0xA0-0xBF form 3-word packets of class 3 (write). Opcodes 0xC0-0xDF form 3-word packets of class 4 (read).
- R9: A word with opcode 0xE0-0xE7 is stored whole into shadow register (opcode & 7). It produces no packet.
- R10: Any other opcode is consumed as a single word. It produces no packet and changes no shadow register, and the following word is decoded as a new opcode.
- R11: A packet that is only partly received is never presented. Its words are kept across any number of idle cycles.
- R12: While outValid is high, inReady is low, and outCount, outClass and outWords stay unchanged until a cycle in which outReady is high. After that cycle outValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input word valid |
| inData | input | 32 | Input command word |
| inReady | output | 1 | Framer can take a word |
| outValid | output | 1 | A complete packet is presented |
| outReady | input | 1 | Consumer takes the packet |
| outClass | output | 3 | Class: 0 draw, 1 polyline, 2 copy, 3 write, 4 read |
| outCount | output | $clog2(MAX_WORDS+1) | Number of words in the packet |
| outWords | output | 32*MAX_WORDS | Packet words, word i at bits 32*i upward |
| shadowRegs | output | 256 | Eight environment shadow registers, register i at bits 32*i upward |

## Verification
The assertions check on every cycle that a presented packet holds steady until it is taken, and that it is gone right after. They also check that its word count stays between 2 and the capacity, that an environment write never yields a packet, and that the shadow registers change only on an environment write. The remaining behaviour can only be seen in the bench's scenarios. That covers the per-opcode lengths and class tags, and the placement of polyline terminators, including decoy words at positions that must be ignored. It also covers the capacity cut-off, dropped opcodes followed by correct re-framing, and partial packets held over idle gaps.

// File: rtl/pktfrm_pkg.sv
package pktfrm_pkg;

  typedef enum logic [2:0] {
    KIND_DROP   = 3'd0,
    KIND_SHADOW = 3'd1,
    KIND_FIXED  = 3'd2,
    KIND_FLAT   = 3'd3,
    KIND_SHADED = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    CLS_DRAW  = 3'd0,
    CLS_POLY  = 3'd1,
    CLS_COPY  = 3'd2,
    CLS_WRITE = 3'd3,
    CLS_READ  = 3'd4
  } cls_e;

  typedef struct packed {
    kind_e      kind;
    cls_e       cls;
    logic [3:0] total;
  } op_info_t;

  typedef struct packed {
    logic store;
    logic shadowWr;
  } strobe_t;

  function automatic op_info_t decodeOp(logic [7:0] op);
    op_info_t info;
    logic [3:0] extra;
    info = '{kind: KIND_DROP, cls: CLS_DRAW, total: 4'd0};
    extra = 4'd0;
    if (op == 8'h02) begin
      info.kind = KIND_FIXED; info.total = 4'd3;
    end else if (op[7:5] == 3'b001) begin
      case (op[4:2])
        3'd0: extra = 4'd3;
        3'd1: extra = 4'd6;
        3'd2: extra = 4'd4;
        3'd3: extra = 4'd8;
        3'd4: extra = 4'd5;
        3'd5: extra = 4'd8;
        3'd6: extra = 4'd7;
        default: extra = 4'd11;
      endcase
      info.kind = KIND_FIXED; info.total = extra + 4'd1;
    end else if (op[7:4] == 4'h4) begin
      if (op[3]) begin
        info.kind = KIND_FLAT; info.cls = CLS_POLY;
      end else begin
        info.kind = KIND_FIXED; info.total = 4'd3;
      end
    end else if (op[7:4] == 4'h5) begin
      if (op[3]) begin
        info.kind = KIND_SHADED; info.cls = CLS_POLY;
      end else begin
        info.kind = KIND_FIXED; info.total = 4'd4;
      end
    end else if (op[7:5] == 3'b011) begin
      case (op[4:2])
        3'd0: extra = 4'd2;
        3'd1: extra = 4'd3;
        3'd2: extra = 4'd1;
        3'd3: extra = 4'd0;
        3'd4: extra = 4'd1;
        3'd5: extra = 4'd2;
        3'd6: extra = 4'd1;
        default: extra = 4'd2;
      endcase
      if (extra != 4'd0) begin
        info.kind = KIND_FIXED; info.total = extra + 4'd1;
      end
    end else if (op[7:5] == 3'b100) begin
      info.kind = KIND_FIXED; info.cls = CLS_COPY; info.total = 4'd4;
    end else if (op[7:5] == 3'b101) begin
      info.kind = KIND_FIXED; info.cls = CLS_WRITE; info.total = 4'd3;
    end else if (op[7:5] == 3'b110) begin
      info.kind = KIND_FIXED; info.cls = CLS_READ; info.total = 4'd3;
    end else if (op[7:3] == 5'b11100) begin
      info.kind = KIND_SHADOW;
    end
    return info;
  endfunction

endpackage

// File: rtl/pktfrm_ctrl.sv
module pktfrm_ctrl
  import pktfrm_pkg::*;
#(
  parameter int MAX_WORDS = 16,
  localparam int IDXW = $clog2(MAX_WORDS),
  localparam int CNTW = $clog2(MAX_WORDS + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [31:0]     inData,
  output logic            inReady,
  input  logic            outReady,
  output logic            outValid,
  output logic [2:0]      outClass,
  output logic [CNTW-1:0] outCount,
  output logic [IDXW-1:0] wordIdx,
  output strobe_t         strb
);

  logic [IDXW-1:0] idxQ;
  kind_e           kindQ;
  cls_e            clsQ;
  logic [3:0]      totalQ;
  logic            outValidQ;
  logic [CNTW-1:0] outCountQ;
  cls_e            outClassQ;

  op_info_t info;
  logic     accept;
  logic     isTerm;
  logic     atCap;
  logic     lastWord;
  logic     starts;

  always_comb begin
    info     = decodeOp(inData[31:24]);
    accept   = inValid && !outValidQ;
    isTerm   = (inData & 32'hF000F000) == 32'h50005000;
    atCap    = idxQ == IDXW'(MAX_WORDS - 1);
    starts   = (info.kind == KIND_FIXED) || (info.kind == KIND_FLAT) ||
               (info.kind == KIND_SHADED);
    lastWord = 1'b0;
    if (idxQ != '0) begin
      case (kindQ)
        KIND_FIXED:  lastWord = (int'(idxQ) + 1) == int'(totalQ);
        KIND_FLAT:   lastWord = (int'(idxQ) >= 3) && isTerm;
        KIND_SHADED: lastWord = (int'(idxQ) >= 4) && !idxQ[0] && isTerm;
        default:     lastWord = 1'b0;
      endcase
      lastWord = lastWord || atCap;
    end
    strb.store    = accept && ((idxQ != '0) || starts);
    strb.shadowWr = accept && (idxQ == '0) && (info.kind == KIND_SHADOW);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ      <= '0;
      kindQ     <= KIND_DROP;
      clsQ      <= CLS_DRAW;
      totalQ    <= '0;
      outValidQ <= 1'b0;
      outCountQ <= '0;
      outClassQ <= CLS_DRAW;
    end else begin
      if (outValidQ && outReady) outValidQ <= 1'b0;
      if (accept) begin
        if (idxQ == '0) begin
          if (starts) begin
            idxQ   <= IDXW'(1);
            kindQ  <= info.kind;
            clsQ   <= info.cls;
            totalQ <= info.total;
          end
        end else if (lastWord) begin
          idxQ      <= '0;
          outValidQ <= 1'b1;
          outCountQ <= CNTW'(idxQ) + CNTW'(1);
          outClassQ <= clsQ;
        end else begin
          idxQ <= idxQ + IDXW'(1);
        end
      end
    end
  end

  assign inReady  = !outValidQ;
  assign outValid = outValidQ;
  assign outCount = outCountQ;
  assign outClass = outClassQ;
  assign wordIdx  = idxQ;

  // R12
  pkt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outCount) && $stable(outClass));

  // R12
  pkt_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady |=> !outValid);

  // R6
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outCount >= CNTW'(2)) && (outCount <= CNTW'(MAX_WORDS)));

  // R9
  shadow_nopkt_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shadowWr |=> !outValid);

endmodule

// File: rtl/pktfrm_dp.sv
module pktfrm_dp
  import pktfrm_pkg::*;
#(
  parameter int MAX_WORDS = 16,
  localparam int IDXW = $clog2(MAX_WORDS),
  localparam int NSHADOW = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [IDXW-1:0]         wordIdx,
  input  logic [31:0]             inData,
  output logic [32*MAX_WORDS-1:0] outWords,
  output logic [32*NSHADOW-1:0]   shadowRegs
);

  logic [MAX_WORDS-1:0][31:0] bufQ;
  logic [NSHADOW-1:0][31:0]   shadowQ;

  for (genvar i = 0; i < MAX_WORDS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strb.store && (wordIdx == IDXW'(i))) bufQ[i] <= inData;
    end
  end

  for (genvar s = 0; s < NSHADOW; s++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (!rstN) shadowQ[s] <= {8'(8'hE0 + s), 24'h0};
      else if (strb.shadowWr && (inData[26:24] == 3'(s))) shadowQ[s] <= inData;
    end
  end

  assign outWords   = bufQ;
  assign shadowRegs = shadowQ;

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shadowWr |=> $stable(shadowRegs));

endmodule

// File: rtl/cmd_packet_framer.sv
module cmd_packet_framer
  import pktfrm_pkg::*;
#(
  parameter int MAX_WORDS = 16,
  localparam int IDXW = $clog2(MAX_WORDS),
  localparam int CNTW = $clog2(MAX_WORDS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [31:0]             inData,
  output logic                    inReady,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [2:0]              outClass,
  output logic [CNTW-1:0]         outCount,
  output logic [32*MAX_WORDS-1:0] outWords,
  output logic [255:0]            shadowRegs
);

  strobe_t         strb;
  logic [IDXW-1:0] wordIdx;

  pktfrm_ctrl #(.MAX_WORDS(MAX_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outReady(outReady), .outValid(outValid),
    .outClass(outClass), .outCount(outCount), .wordIdx(wordIdx), .strb(strb)
  );

  pktfrm_dp #(.MAX_WORDS(MAX_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wordIdx(wordIdx), .inData(inData),
    .outWords(outWords), .shadowRegs(shadowRegs)
  );

endmodule

// File: tb/cmd_packet_framer_test.sv
module cmd_packet_framer_test;

  localparam int CLK_PERIOD = 10;
  localparam int MAXW = 16;
  localparam int CW = $clog2(MAXW + 1);

  // entry: {opcode, total words, class, 8'h00}
  localparam logic [31:0] VEC [23] = '{
    32'h02_03_00_00, 32'h20_04_00_00, 32'h25_07_00_00, 32'h2A_05_00_00,
    32'h2F_09_00_00, 32'h31_06_00_00, 32'h36_09_00_00, 32'h3B_08_00_00,
    32'h3C_0C_00_00, 32'h44_03_00_00, 32'h52_04_00_00, 32'h61_03_00_00,
    32'h66_04_00_00, 32'h6A_02_00_00, 32'h71_02_00_00, 32'h77_03_00_00,
    32'h79_02_00_00, 32'h7E_03_00_00, 32'h88_04_02_00, 32'hA0_03_03_00,
    32'hBF_03_03_00, 32'hC4_03_04_00, 32'hDF_03_04_00
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] inData = '0;
  logic inReady, outValid;
  logic outReady = 1'b0;
  logic [2:0] outClass;
  logic [CW-1:0] outCount;
  logic [32*MAXW-1:0] outWords;
  logic [255:0] shadowRegs;

  int total = 0;
  int bad = 0;
  logic [31:0] pkt [MAXW];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_packet_framer #(.MAX_WORDS(MAXW)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outReady(outReady),
    .outClass(outClass), .outCount(outCount), .outWords(outWords),
    .shadowRegs(shadowRegs)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendWord(logic [31:0] d);
    inData = d;
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic sendSeq(int n);
    for (int k = 0; k < n; k++) sendWord(pkt[k]);
  endtask

  task automatic fillPkt(logic [7:0] op, int n, int seed);
    pkt[0] = {op, 24'h00A5C3 ^ 24'(seed)};
    for (int k = 1; k < MAXW; k++) pkt[k] = 32'h01020304 + 32'(k * 32'h00010001);
    if (n < 1) pkt[0] = pkt[0];
  endtask

  task automatic expectPkt(string tag, int n, int cls);
    int miss;
    miss = 0;
    chk({tag, " valid"}, 32'(outValid), 32'd1);
    chk({tag, " count"}, 32'(outCount), 32'(n));
    chk({tag, " class"}, 32'(outClass), 32'(cls));
    for (int k = 0; k < n; k++)
      if (outWords[32*k +: 32] !== pkt[k]) miss++;
    chk({tag, " words"}, 32'(miss), 32'd0);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    chk({tag, " released"}, 32'(outValid), 32'd0);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 inReady", 32'(inReady), 32'd1);
    chk("R1 outValid", 32'(outValid), 32'd0);
    for (int s = 0; s < 8; s++)
      chk("R1 shadow", shadowRegs[32*s +: 32], {8'(8'hE0 + s), 24'h0});

    // R2 R3 R7 R8 table of fixed-length opcodes
    for (int i = 0; i < 23; i++) begin
      fillPkt(VEC[i][31:24], int'(VEC[i][23:16]), i);
      sendSeq(int'(VEC[i][23:16]));
      expectPkt($sformatf("R2/R3/R7/R8 op=%h", VEC[i][31:24]),
                int'(VEC[i][23:16]), int'(VEC[i][15:8]));
    end

    // R4 flat polyline, early match at index 1 ignored, ends at index 3
    fillPkt(8'h48, 4, 40);
    pkt[1] = 32'h50005000;
    pkt[3] = 32'h5AB35CD7;
    sendSeq(4);
    expectPkt("R4 flat min", 4, 1);

    // R4 flat polyline ending at index 5
    fillPkt(8'h4C, 6, 41);
    pkt[5] = 32'h51235FFF;
    sendSeq(6);
    expectPkt("R4 flat long", 6, 1);

    // R5 shaded polyline: terminators at index 3 and 5 ignored, ends at 6
    fillPkt(8'h5A, 7, 42);
    pkt[3] = 32'h55555555;
    pkt[5] = 32'h50005000;
    pkt[6] = 32'h5F0F5F0F;
    sendSeq(7);
    expectPkt("R5 shaded", 7, 1);

    // R6 polyline with no terminator stops at capacity
    fillPkt(8'h4B, MAXW, 43);
    sendSeq(MAXW);
    expectPkt("R6 capacity", MAXW, 1);
    fillPkt(8'h02, 3, 44);
    sendSeq(3);
    expectPkt("R6 next packet", 3, 0);

    // R9 environment writes
    sendWord(32'hE3123456);
    chk("R9 no packet", 32'(outValid), 32'd0);
    chk("R9 shadow3", shadowRegs[32*3 +: 32], 32'hE3123456);
    sendWord(32'hE7ABCDEF);
    chk("R9 shadow7", shadowRegs[32*7 +: 32], 32'hE7ABCDEF);
    chk("R9 shadow0 kept", shadowRegs[31:0], 32'hE0000000);

    // R10 dropped opcodes
    sendWord(32'h6D000000);
    sendWord(32'hE9ABCDEF);
    sendWord(32'h00000000);
    sendWord(32'h01FFFFFF);
    chk("R10 no packet", 32'(outValid), 32'd0);
    chk("R10 shadow1 kept", shadowRegs[32*1 +: 32], 32'hE1000000);
    chk("R10 shadow7 kept", shadowRegs[32*7 +: 32], 32'hE7ABCDEF);
    fillPkt(8'h02, 3, 45);
    sendSeq(3);
    expectPkt("R10 reframe", 3, 0);

    // R11 partial packet held across an idle gap
    fillPkt(8'h24, 7, 46);
    for (int k = 0; k < 3; k++) sendWord(pkt[k]);
    repeat (6) @(negedge clk);
    chk("R11 partial hidden", 32'(outValid), 32'd0);
    for (int k = 3; k < 7; k++) sendWord(pkt[k]);
    expectPkt("R11 completed", 7, 0);

    // R12 back-pressure while a packet waits
    fillPkt(8'h6A, 2, 47);
    sendSeq(2);
    inData = 32'h02ABCDEF;
    inValid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 inReady low", 32'(inReady), 32'd0);
    chk("R12 held valid", 32'(outValid), 32'd1);
    chk("R12 held count", 32'(outCount), 32'd2);
    chk("R12 held word1", outWords[63:32], pkt[1]);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    chk("R12 released", 32'(outValid), 32'd0);
    @(negedge clk);
    inValid = 1'b0;
    fillPkt(8'h02, 3, 48);
    pkt[0] = 32'h02ABCDEF;
    sendWord(pkt[1]);
    sendWord(pkt[2]);
    expectPkt("R12 stalled word kept", 3, 0);

    summary();
    $finish;
  end

endmodule